// File: doc/BRIEF.md
# Hybrid Reduced-CMV Modulation Wave Generator

This block feeds the phase-leg modulators of a three-level inverter. Once per switching period it takes a strobe and three signed fixed-point phase references. It ranks them into a highest, middle and lowest role and derives two duty thresholds per phase. The upper threshold is the share of the period spent in the positive state. The lower threshold marks the point where the leg leaves the zero state for the negative state. The thresholds are built so that every phase spends the same time in the zero (clamped) state, which makes the neutral-point current average to zero over the period.

Alongside the thresholds, the block raises one reversal bit per period. This bit tells the modulator of the chosen phase to use the inverted carrier, which keeps the common-mode voltage within one sixth of the link voltage. The bit is always on the highest or the lowest phase, never the middle one. The choice between those two flips at the midpoint of each 60-degree sector, which is where the middle reference crosses zero, so each phase takes the reversal equally often over a fundamental cycle.

References are two's complement with `FRAC_W` fractional bits, so unity is `2**FRAC_W`. The thresholds are unsigned values in the same scale, limited to the range 0 to unity.

Top module: `cdw_dualwave_gen`

## Requirements
- R1: The three references are ranked each period. When values tie, the highest role goes to the earliest tied phase in the order A, B, C and the lowest role to the latest, so the three roles are always a permutation of the phases (all equal: A highest, B middle, C lowest).
- R2: Each phase's upper threshold is floor((own reference - lowest reference)/2), limited to at most unity. The lowest phase therefore gets 0.
- R3: Each phase's lower threshold equals its upper threshold plus the common zero-state duty. The highest phase therefore gets exactly unity.
- R4: The lower minus the upper threshold (the zero-state duty) is the same for all three phases. It equals unity - min(floor((highest - lowest)/2), unity).
- R5: Exactly one bit of `rev_sel` is set per result (bit 0 = phase A, bit 1 = phase B, bit 2 = phase C). It marks the highest phase when the middle reference is negative, and the lowest phase when the middle reference is zero or positive.
- R6: When floor((highest - lowest)/2) exceeds unity, the upper thresholds are limited to unity, the zero-state duty is 0 and each lower threshold equals its upper threshold. No threshold ever leaves 0 to unity.
- R7: A result appears with `out_valid` high exactly two clock cycles after each accepted `in_valid`, one result per strobe, back-to-back strobes included. While `out_valid` is low, all outputs hold their last values.
- R8: During and right after reset, `out_valid`, all thresholds and `rev_sel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Reference strobe, one per switching period |
| ref_a | input | REF_W | Phase A reference, signed, FRAC_W fractional bits |
| ref_b | input | REF_W | Phase B reference |
| ref_c | input | REF_W | Phase C reference |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| pos_a | output | REF_W | Phase A upper threshold, unsigned 0..unity |
| pos_b | output | REF_W | Phase B upper threshold |
| pos_c | output | REF_W | Phase C upper threshold |
| neg_a | output | REF_W | Phase A lower threshold, unsigned 0..unity |
| neg_b | output | REF_W | Phase B lower threshold |
| neg_c | output | REF_W | Phase C lower threshold |
| rev_sel | output | 3 | One-hot inverted-carrier select, bit 0 = A |

## Verification
The bench builds the block with REF_W = 12 and FRAC_W = 10. This makes unity 1024 while the inputs span roughly ±2.0. Codes near the input limits then drive the half-range past unity, so the saturation path of R6 can be reached alongside ordinary sine samples. The narrow word also makes odd differences, and the floor halving they involve, frequent among the random vectors. Hand-picked ties and a zero-valued middle reference exercise the rank priority and the reversal boundary.

// File: rtl/cdw_pkg.sv
package cdw_pkg;
  localparam int NPH = 3;
  typedef logic [1:0] phase_t;
  localparam phase_t PH_A = 2'd0;
  localparam phase_t PH_B = 2'd1;
  localparam phase_t PH_C = 2'd2;
endpackage

// File: rtl/cdw_rank.sv
module cdw_rank
  import cdw_pkg::*;
#(
  parameter int REF_W = 16
) (
  input  logic signed [REF_W-1:0] ref_a,
  input  logic signed [REF_W-1:0] ref_b,
  input  logic signed [REF_W-1:0] ref_c,
  output phase_t                  hi_idx,
  output phase_t                  lo_idx,
  output logic signed [REF_W-1:0] hi_val,
  output logic signed [REF_W-1:0] lo_val,
  output logic                    mid_neg
);
  phase_t mid_idx;
  logic signed [REF_W-1:0] mid_val;

  function automatic logic signed [REF_W-1:0] pick(
    input phase_t                  idx,
    input logic signed [REF_W-1:0] va,
    input logic signed [REF_W-1:0] vb,
    input logic signed [REF_W-1:0] vc
  );
    case (idx)
      PH_A:    return va;
      PH_B:    return vb;
      default: return vc;
    endcase
  endfunction

  // highest: earliest tied phase wins
  always_comb begin
    if (ref_a >= ref_b && ref_a >= ref_c) hi_idx = PH_A;
    else if (ref_b >= ref_c)              hi_idx = PH_B;
    else                                  hi_idx = PH_C;
  end

  // lowest: latest tied phase wins, so all-equal still yields a permutation
  always_comb begin
    if (ref_c <= ref_a && ref_c <= ref_b) lo_idx = PH_C;
    else if (ref_b <= ref_a)              lo_idx = PH_B;
    else                                  lo_idx = PH_A;
  end

  assign mid_idx = phase_t'(2'd3 - hi_idx - lo_idx);
  assign hi_val  = pick(hi_idx, ref_a, ref_b, ref_c);
  assign lo_val  = pick(lo_idx, ref_a, ref_b, ref_c);
  assign mid_val = pick(mid_idx, ref_a, ref_b, ref_c);
  assign mid_neg = mid_val[REF_W-1];
endmodule

// File: rtl/cdw_wave.sv
module cdw_wave #(
  parameter int REF_W  = 16,
  parameter int FRAC_W = 14
) (
  input  logic signed [REF_W-1:0] own_ref,
  input  logic signed [REF_W-1:0] hi_ref,
  input  logic signed [REF_W-1:0] lo_ref,
  output logic        [REF_W-1:0] pos_thr,
  output logic        [REF_W-1:0] neg_thr
);
  localparam logic [REF_W-1:0] UNITY = REF_W'(1) << FRAC_W;

  // floor((upper - lower)/2) for upper >= lower; fits REF_W unsigned bits
  function automatic logic [REF_W-1:0] half_gap(
    input logic signed [REF_W-1:0] upper,
    input logic signed [REF_W-1:0] lower
  );
    logic signed [REF_W:0] gap;
    gap = $signed({upper[REF_W-1], upper}) - $signed({lower[REF_W-1], lower});
    return gap[REF_W:1];
  endfunction

  function automatic logic [REF_W-1:0] cap_unity(input logic [REF_W-1:0] v);
    return (v > UNITY) ? UNITY : v;
  endfunction

  logic [REF_W-1:0] half_span;
  logic [REF_W-1:0] half_own;
  logic [REF_W-1:0] zero_duty;

  assign half_span = cap_unity(half_gap(hi_ref, lo_ref));
  assign half_own  = half_gap(own_ref, lo_ref);
  assign zero_duty = UNITY - half_span;
  assign pos_thr   = cap_unity(half_own);
  assign neg_thr   = pos_thr + zero_duty;
endmodule

// File: rtl/cdw_revsel.sv
module cdw_revsel
  import cdw_pkg::*;
(
  input  phase_t         hi_idx,
  input  phase_t         lo_idx,
  input  logic           mid_neg,
  output logic [NPH-1:0] rev
);
  phase_t chosen;
  assign chosen = mid_neg ? hi_idx : lo_idx;

  for (genvar p = 0; p < NPH; p++) begin : g_bit
    assign rev[p] = (chosen == phase_t'(p));
  end
endmodule

// File: rtl/cdw_dualwave_gen.sv
module cdw_dualwave_gen
  import cdw_pkg::*;
#(
  parameter int REF_W  = 16,
  parameter int FRAC_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [REF_W-1:0] ref_a,
  input  logic signed [REF_W-1:0] ref_b,
  input  logic signed [REF_W-1:0] ref_c,
  output logic                    out_valid,
  output logic        [REF_W-1:0] pos_a,
  output logic        [REF_W-1:0] pos_b,
  output logic        [REF_W-1:0] pos_c,
  output logic        [REF_W-1:0] neg_a,
  output logic        [REF_W-1:0] neg_b,
  output logic        [REF_W-1:0] neg_c,
  output logic        [2:0]       rev_sel
);
  // ranking (combinational, stage 0)
  phase_t                  r_hi_idx, r_lo_idx;
  logic signed [REF_W-1:0] r_hi_val, r_lo_val;
  logic                    r_mid_neg;

  cdw_rank #(.REF_W(REF_W)) u_rank (
    .ref_a   (ref_a),
    .ref_b   (ref_b),
    .ref_c   (ref_c),
    .hi_idx  (r_hi_idx),
    .lo_idx  (r_lo_idx),
    .hi_val  (r_hi_val),
    .lo_val  (r_lo_val),
    .mid_neg (r_mid_neg)
  );

  // stage 1 registers
  logic                    s1_valid;
  logic signed [REF_W-1:0] s1_ref [NPH];
  logic signed [REF_W-1:0] s1_hi_val, s1_lo_val;
  phase_t                  s1_hi_idx, s1_lo_idx;
  logic                    s1_mid_neg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      s1_ref[0]  <= '0;
      s1_ref[1]  <= '0;
      s1_ref[2]  <= '0;
      s1_hi_val  <= '0;
      s1_lo_val  <= '0;
      s1_hi_idx  <= PH_A;
      s1_lo_idx  <= PH_C;
      s1_mid_neg <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_ref[0]  <= ref_a;
        s1_ref[1]  <= ref_b;
        s1_ref[2]  <= ref_c;
        s1_hi_val  <= r_hi_val;
        s1_lo_val  <= r_lo_val;
        s1_hi_idx  <= r_hi_idx;
        s1_lo_idx  <= r_lo_idx;
        s1_mid_neg <= r_mid_neg;
      end
    end
  end

  // stage 2 arithmetic, one wave unit per phase
  logic [REF_W-1:0] w_pos [NPH];
  logic [REF_W-1:0] w_neg [NPH];
  logic [NPH-1:0]   w_rev;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    cdw_wave #(.REF_W(REF_W), .FRAC_W(FRAC_W)) u_wave (
      .own_ref (s1_ref[p]),
      .hi_ref  (s1_hi_val),
      .lo_ref  (s1_lo_val),
      .pos_thr (w_pos[p]),
      .neg_thr (w_neg[p])
    );
  end

  cdw_revsel u_rev (
    .hi_idx  (s1_hi_idx),
    .lo_idx  (s1_lo_idx),
    .mid_neg (s1_mid_neg),
    .rev     (w_rev)
  );

  // stage 2 registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pos_a     <= '0;
      pos_b     <= '0;
      pos_c     <= '0;
      neg_a     <= '0;
      neg_b     <= '0;
      neg_c     <= '0;
      rev_sel   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        pos_a   <= w_pos[0];
        pos_b   <= w_pos[1];
        pos_c   <= w_pos[2];
        neg_a   <= w_neg[0];
        neg_b   <= w_neg[1];
        neg_c   <= w_neg[2];
        rev_sel <= w_rev;
      end
    end
  end
endmodule

// File: rtl/cdw_dualwave_chk.sv
module cdw_dualwave_chk #(
  parameter int REF_W  = 16,
  parameter int FRAC_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             s1_valid,
  input logic             out_valid,
  input logic [REF_W-1:0] pos_a,
  input logic [REF_W-1:0] pos_b,
  input logic [REF_W-1:0] pos_c,
  input logic [REF_W-1:0] neg_a,
  input logic [REF_W-1:0] neg_b,
  input logic [REF_W-1:0] neg_c,
  input logic [2:0]       rev_sel
);
  localparam logic [REF_W-1:0] UNITY = REF_W'(1) << FRAC_W;

  AST_REV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(rev_sel) == 1); // R5

  AST_REV_EXTREME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((!rev_sel[0] || neg_a == UNITY || pos_a == '0) &&
                   (!rev_sel[1] || neg_b == UNITY || pos_b == '0) &&
                   (!rev_sel[2] || neg_c == UNITY || pos_c == '0))); // R5

  AST_EXTREMES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((neg_a == UNITY || neg_b == UNITY || neg_c == UNITY) &&
                   (pos_a == '0 || pos_b == '0 || pos_c == '0))); // R3

  AST_ZERO_DUTY_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((neg_a - pos_a) == (neg_b - pos_b) &&
                   (neg_b - pos_b) == (neg_c - pos_c))); // R4

  AST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pos_a <= neg_a && pos_b <= neg_b && pos_c <= neg_c &&
                   neg_a <= UNITY && neg_b <= UNITY && neg_c <= UNITY)); // R6

  AST_STAGE1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid); // R7

  AST_STAGE2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid); // R7

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s1_valid)); // R7

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(pos_a) && $stable(neg_c) && $stable(rev_sel))); // R7
endmodule

bind cdw_dualwave_gen cdw_dualwave_chk #(.REF_W(REF_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .s1_valid  (s1_valid),
  .out_valid (out_valid),
  .pos_a     (pos_a),
  .pos_b     (pos_b),
  .pos_c     (pos_c),
  .neg_a     (neg_a),
  .neg_b     (neg_b),
  .neg_c     (neg_c),
  .rev_sel   (rev_sel)
);

// File: tb/cdw_dualwave_gen_tb_top.sv
`timescale 1ns/1ps
module cdw_dualwave_gen_tb_top;
  localparam int W    = 12;
  localparam int F    = 10;
  localparam int ONE  = 1 << F;
  localparam int VMAX = (1 << (W-1)) - 1;
  localparam int VMIN = -(1 << (W-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [W-1:0] ref_a = '0, ref_b = '0, ref_c = '0;
  logic out_valid;
  logic [W-1:0] pos_a, pos_b, pos_c, neg_a, neg_b, neg_c;
  logic [2:0] rev_sel;

  always #2.5 clk = ~clk;

  cdw_dualwave_gen #(.REF_W(W), .FRAC_W(F)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .out_valid(out_valid),
    .pos_a(pos_a), .pos_b(pos_b), .pos_c(pos_c),
    .neg_a(neg_a), .neg_b(neg_b), .neg_c(neg_c),
    .rev_sel(rev_sel)
  );

  typedef struct {
    int pos [3];
    int neg [3];
    int rev;
    int duty;
    bit sat;
    int stamp;
  } exp_t;

  exp_t sb_q [$];
  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int pushed = 0;
  int popped = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic exp_t model(input int a, input int b, input int c);
    exp_t e;
    int v [3];
    int hi, lo, md, h, hc, d;
    v[0] = a; v[1] = b; v[2] = c;
    hi = 0;
    for (int p = 1; p < 3; p++) if (v[p] > v[hi]) hi = p;
    lo = 2;
    for (int p = 1; p >= 0; p--) if (v[p] < v[lo]) lo = p;
    md = 3 - hi - lo;
    h  = (v[hi] - v[lo]) / 2;
    hc = (h > ONE) ? ONE : h;
    for (int p = 0; p < 3; p++) begin
      d = (v[p] - v[lo]) / 2;
      e.pos[p] = (d > ONE) ? ONE : d;
      e.neg[p] = e.pos[p] + ONE - hc;
    end
    e.rev  = 1 << ((v[md] < 0) ? hi : lo);
    e.duty = ONE - hc;
    e.sat  = (h > ONE);
    e.stamp = 0;
    return e;
  endfunction

  task automatic send(input int a, input int b, input int c);
    exp_t e;
    @(negedge clk);
    ref_a = W'(a); ref_b = W'(b); ref_c = W'(c);
    in_valid = 1'b1;
    e = model(a, b, c);
    e.stamp = cyc;
    sb_q.push_back(e);
    pushed++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      ref_a = W'($urandom_range(4095));
      ref_b = W'($urandom_range(4095));
    end
  endtask

  // monitor / scoreboard
  initial begin
    int lp [3];
    int ln [3];
    int lr;
    exp_t e;
    string rq;
    lp = '{0, 0, 0}; ln = '{0, 0, 0}; lr = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (out_valid) begin
          if (sb_q.size() == 0) begin
            check(1'b0, "R7", "unexpected result", 1, 0);
          end else begin
            e = sb_q.pop_front();
            popped++;
            rq = e.sat ? "R6" : "R2";
            check(int'(pos_a) == e.pos[0], rq, "pos_a", int'(pos_a), e.pos[0]);
            check(int'(pos_b) == e.pos[1], rq, "pos_b", int'(pos_b), e.pos[1]);
            check(int'(pos_c) == e.pos[2], rq, "pos_c", int'(pos_c), e.pos[2]);
            check(int'(neg_a) == e.neg[0], "R3", "neg_a", int'(neg_a), e.neg[0]);
            check(int'(neg_b) == e.neg[1], "R3", "neg_b", int'(neg_b), e.neg[1]);
            check(int'(neg_c) == e.neg[2], "R3", "neg_c", int'(neg_c), e.neg[2]);
            check(int'(neg_b) - int'(pos_b) == e.duty, "R4", "zero duty b",
                  int'(neg_b) - int'(pos_b), e.duty);
            check(int'(rev_sel) == e.rev, "R1/R5", "rev_sel", int'(rev_sel), e.rev);
            check(cyc - e.stamp == 2, "R7", "latency", cyc - e.stamp, 2);
          end
          lp[0] = int'(pos_a); lp[1] = int'(pos_b); lp[2] = int'(pos_c);
          ln[0] = int'(neg_a); ln[1] = int'(neg_b); ln[2] = int'(neg_c);
          lr = int'(rev_sel);
        end else if (popped > 0) begin
          check(int'(pos_a) == lp[0] && int'(pos_c) == lp[2] && int'(neg_b) == ln[1] &&
                int'(rev_sel) == lr, "R7", "hold pos_a", int'(pos_a), lp[0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    check(pos_a == '0 && neg_c == '0, "R8", "thresholds in reset", int'(neg_c), 0);
    check(rev_sel == '0, "R8", "rev_sel in reset", int'(rev_sel), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && pos_b == '0, "R8", "after reset", int'(out_valid), 0);

    // R1 ties, R5 zero middle selects the lowest phase
    send(0, 0, 0);              // hi A, mid B (0), lo C -> rev C
    send(300, 300, -100);       // hi A (tie), lo C
    send(-200, 500, -200);      // hi B, lo C (latest tie), mid A negative -> rev B
    send(ONE, -ONE/2, -ONE/2);  // mid negative -> rev A
    send(-ONE, ONE/2, ONE/2);   // mid positive -> rev A (lowest)
    idle(3);
    // odd differences, R2 floor halving
    send(3, 0, -2);
    send(-7, 5, 2);
    idle(1);
    // R6 saturation
    send(VMAX, VMIN, 0);
    send(VMIN, VMAX, VMAX);
    send(1500, -1500, 200);
    idle(4);
    // sine sweep across all sectors, m = 0.9
    for (int k = 0; k < 48; k++) begin
      real th;
      th = 2.0 * 3.14159265358979 * k / 48.0;
      send(int'(0.9 * ONE * $cos(th)),
           int'(0.9 * ONE * $cos(th - 2.0943951023932)),
           int'(0.9 * ONE * $cos(th + 2.0943951023932)));
      if (k % 5 == 4) idle(2);
    end
    idle(2);
    // random vectors over the full input range
    for (int k = 0; k < 80; k++) begin
      send(int'($urandom_range(4095)) - 2048,
           int'($urandom_range(4095)) - 2048,
           int'($urandom_range(4095)) - 2048);
      if (k % 7 == 6) idle(1);
    end
    idle(6);
    check(popped == pushed, "R7", "result count", popped, pushed);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule